// File: doc/BRIEF.md
# Oscillator and PLL Control Registers

This block is the register front end for a chip's crystal oscillators and two PLLs. Software uses a plain 32-bit register port to write four words: a general control word with per-timer reference selects, an oscillator control word, a PLL control word and a PLL frequency word. From these words the block produces the effective run enable for each oscillator and PLL, and it computes the output rate of each PLL as a number from a reference rate input. The analog parts are outside the block. It only sends them enables and samples their lock status back.

The main crystal and PLL1 run from hardware by default. A software enable bit only has an effect while the matching override bit is 1. PLL2 and the secondary crystal follow their software bits directly. A dedicated request input forces the main crystal on so that a chip reset can proceed.

Top module: `osc_pll_regs`

## Requirements
- R1: A synchronous active-low reset clears every stored bit to 0, except the main-crystal enable (oscillator word bit 1), which resets to 1. After reset the words read 0x0, 0x2, 0x0 and 0x0 at offsets 0x00, 0x0C, 0x10 and 0x14, provided the lock inputs are low.
- R2: At offset 0x00, bit 15+2*i holds the slow-reference select for timer i, for i = 0..7, and drives `tmr_slow_sel[i]`. All other bits of this word read 0.
- R3: The oscillator word has the main-crystal override at bit 0 and the main-crystal enable at bit 1. `mxtal_run` equals the enable bit while the override is 1, and equals 1 while the override is 0.
- R4: The PLL word has the PLL1 override at bit 0 and the PLL1 enable at bit 1. `pll1_run` equals the enable bit while the override is 1, and equals 1 while the override is 0.
- R5: `pll2_run` equals PLL word bit 28. `sxtal_run` equals the inverse of oscillator word bit 19, the secondary-crystal disable.
- R6: Bit 2 of the oscillator word and bit 2 of the PLL word read the main-crystal and PLL1 lock inputs as registered on the previous clock edge. Writes to these bits have no effect.
- R7: The frequency word has M1 at bits 13:8, D at bits 2:0 and M2 at bits 29:24. All other bits read 0. `pll1_rate` = (`ref_rate` * (M1+2)) >> D, computed without truncation in 40 bits.
- R8: `pll2_rate` = `ref_rate` * (M2+2), with no post shift.
- R9: A cycle with `mxtal_force_on` high clears the main-crystal override and sets the main-crystal enable. This takes precedence over a bus write in the same cycle and leaves the other oscillator bits unchanged.
- R10: Oscillator word bit 20 drives `osc_tmr_en` and PLL word bit 29 drives `pll_tmr_en`. Both bits read back as written.
- R11: Offsets other than 0x00, 0x0C, 0x10 and 0x14 read 0. Writes to them change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| mxtal_force_on | input | 1 | Request to force the main crystal on |
| mxtal_lock | input | 1 | Main-crystal ready status from the analog part |
| pll1_lock | input | 1 | PLL1 lock status from the analog part |
| ref_rate | input | 32 | Reference rate value fed to both PLL rate calculations |
| tmr_slow_sel | output | 8 | Per-timer slow-reference select |
| mxtal_run | output | 1 | Effective main-crystal enable |
| sxtal_run | output | 1 | Effective secondary-crystal enable |
| pll1_run | output | 1 | Effective PLL1 enable |
| pll2_run | output | 1 | Effective PLL2 enable |
| osc_tmr_en | output | 1 | Oscillator timer enable |
| pll_tmr_en | output | 1 | PLL timer enable |
| pll1_rate | output | 40 | Computed PLL1 output rate |
| pll2_rate | output | 40 | Computed PLL2 output rate |

## Verification
The bench uses the default parameters: a 32-bit reference, 6-bit multiplier fields and a 3-bit shift. With these widths the full field space is small. Every M1 and D pair, and every M2 value, is swept at four reference values, including the all-ones maximum, so the widest product is exercised. Each override and enable combination is applied to both gated enables. The force request is checked both alone and when it collides with a bus write.

// File: rtl/osc_pll_pkg.sv
// Package: word offsets, bit positions and field types shared by the
// oscillator/PLL control register block. Offsets and bit positions are
// decoded by software, so they are fixed here rather than parameters.
package osc_pll_pkg;

    localparam int unsigned OFS_CTRL = 'h00;
    localparam int unsigned OFS_OSC  = 'h0C;
    localparam int unsigned OFS_PLL  = 'h10;
    localparam int unsigned OFS_FREQ = 'h14;

    localparam int TMR_BASE    = 15;   // timer i select at TMR_BASE + 2*i

    localparam int OSC_OVR_B   = 0;
    localparam int OSC_EN_B    = 1;
    localparam int OSC_STAT_B  = 2;
    localparam int OSC_SXDIS_B = 19;
    localparam int OSC_TMR_B   = 20;

    localparam int PLL_OVR_B   = 0;
    localparam int PLL_EN_B    = 1;
    localparam int PLL_STAT_B  = 2;
    localparam int PLL2_EN_B   = 28;
    localparam int PLL_TMR_B   = 29;

    localparam int FRQ_D_LSB   = 0;
    localparam int FRQ_M1_LSB  = 8;
    localparam int FRQ_M2_LSB  = 24;

    localparam int MUL_OFS     = 2;    // multiplier code offset

    typedef struct packed {
        logic tmr_en;
        logic sx_dis;
        logic mx_en;
        logic mx_ovr;
    } osc_ctl_t;

    typedef struct packed {
        logic tmr_en;
        logic p2_en;
        logic p1_en;
        logic p1_ovr;
    } pll_ctl_t;

endpackage

// File: rtl/osc_pll_csr.sv
// Module: osc_pll_csr
// Holds the four control words, decodes bus writes, applies the
// main-crystal force request and samples the lock status inputs.
// Assumes one access per cycle; reads are combinational on bus_addr.
module osc_pll_csr
    import osc_pll_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int NUM_TMR = 8,
    parameter int MUL_W   = 6,
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               force_mx_on,
    input  logic               mx_lock_i,
    input  logic               p1_lock_i,
    output osc_ctl_t           osc_q,
    output pll_ctl_t           pll_q,
    output logic [NUM_TMR-1:0] tmr_q,
    output logic [MUL_W-1:0]   m1_q,
    output logic [SHIFT_W-1:0] d1_q,
    output logic [MUL_W-1:0]   m2_q
);

    logic hit_ctrl, hit_osc, hit_pll, hit_freq;
    logic mx_stat_q, p1_stat_q;
    logic [NUM_TMR-1:0] tmr_wval;
    osc_ctl_t osc_d;

    assign hit_ctrl = wr_en && (addr == ADDR_W'(OFS_CTRL));
    assign hit_osc  = wr_en && (addr == ADDR_W'(OFS_OSC));
    assign hit_pll  = wr_en && (addr == ADDR_W'(OFS_PLL));
    assign hit_freq = wr_en && (addr == ADDR_W'(OFS_FREQ));

    // Gather the odd-position timer select bits from the write data.
    genvar g;
    generate
        for (g = 0; g < NUM_TMR; g++) begin : g_tmr_wr
            assign tmr_wval[g] = wdata[TMR_BASE + 2*g];
        end
    endgenerate

    // Timer select storage.
    always_ff @(posedge clk) begin
        if (!rst_n)        tmr_q <= '0;
        else if (hit_ctrl) tmr_q <= tmr_wval;
    end

    // Next oscillator word: bus write first, force request overrides it.
    always_comb begin
        osc_d = osc_q;
        if (hit_osc) begin
            osc_d.mx_ovr = wdata[OSC_OVR_B];
            osc_d.mx_en  = wdata[OSC_EN_B];
            osc_d.sx_dis = wdata[OSC_SXDIS_B];
            osc_d.tmr_en = wdata[OSC_TMR_B];
        end
        if (force_mx_on) begin
            osc_d.mx_ovr = 1'b0;
            osc_d.mx_en  = 1'b1;
        end
    end

    // Oscillator word storage; main-crystal enable resets high.
    always_ff @(posedge clk) begin
        if (!rst_n) osc_q <= '{tmr_en: 1'b0, sx_dis: 1'b0, mx_en: 1'b1, mx_ovr: 1'b0};
        else        osc_q <= osc_d;
    end

    // PLL control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) pll_q <= '0;
        else if (hit_pll) begin
            pll_q.p1_ovr <= wdata[PLL_OVR_B];
            pll_q.p1_en  <= wdata[PLL_EN_B];
            pll_q.p2_en  <= wdata[PLL2_EN_B];
            pll_q.tmr_en <= wdata[PLL_TMR_B];
        end
    end

    // PLL frequency field storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m1_q <= '0;
            d1_q <= '0;
            m2_q <= '0;
        end else if (hit_freq) begin
            m1_q <= wdata[FRQ_M1_LSB +: MUL_W];
            d1_q <= wdata[FRQ_D_LSB  +: SHIFT_W];
            m2_q <= wdata[FRQ_M2_LSB +: MUL_W];
        end
    end

    // Register the external lock status once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mx_stat_q <= 1'b0;
            p1_stat_q <= 1'b0;
        end else begin
            mx_stat_q <= mx_lock_i;
            p1_stat_q <= p1_lock_i;
        end
    end

    // Read mux; unmapped offsets and reserved bits return zero.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CTRL)) begin
            for (int i = 0; i < NUM_TMR; i++) rdata[TMR_BASE + 2*i] = tmr_q[i];
        end else if (addr == ADDR_W'(OFS_OSC)) begin
            rdata[OSC_OVR_B]   = osc_q.mx_ovr;
            rdata[OSC_EN_B]    = osc_q.mx_en;
            rdata[OSC_STAT_B]  = mx_stat_q;
            rdata[OSC_SXDIS_B] = osc_q.sx_dis;
            rdata[OSC_TMR_B]   = osc_q.tmr_en;
        end else if (addr == ADDR_W'(OFS_PLL)) begin
            rdata[PLL_OVR_B]   = pll_q.p1_ovr;
            rdata[PLL_EN_B]    = pll_q.p1_en;
            rdata[PLL_STAT_B]  = p1_stat_q;
            rdata[PLL2_EN_B]   = pll_q.p2_en;
            rdata[PLL_TMR_B]   = pll_q.tmr_en;
        end else if (addr == ADDR_W'(OFS_FREQ)) begin
            rdata[FRQ_M1_LSB +: MUL_W] = m1_q;
            rdata[FRQ_D_LSB  +: SHIFT_W] = d1_q;
            rdata[FRQ_M2_LSB +: MUL_W] = m2_q;
        end
    end

    // R9
    force_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_mx_on |=> (!osc_q.mx_ovr && osc_q.mx_en));

    // R11
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !force_mx_on && !hit_ctrl && !hit_osc && !hit_pll && !hit_freq)
        |=> ($stable(osc_q) && $stable(pll_q) && $stable(tmr_q)
             && $stable(m1_q) && $stable(d1_q) && $stable(m2_q)));

endmodule

// File: rtl/osc_pll_enables.sv
// Module: osc_pll_enables
// Turns the stored control bits into effective run enables. The main
// crystal and PLL1 follow software only while their override is set;
// otherwise they are held running. Purely combinational.
module osc_pll_enables
    import osc_pll_pkg::*;
(
    input  osc_ctl_t osc_q,
    input  pll_ctl_t pll_q,
    output logic     mx_run,
    output logic     sx_run,
    output logic     p1_run,
    output logic     p2_run,
    output logic     osc_tmr,
    output logic     pll_tmr
);

    // Override-gated and direct enables.
    always_comb begin
        mx_run  = osc_q.mx_ovr ? osc_q.mx_en : 1'b1;
        p1_run  = pll_q.p1_ovr ? pll_q.p1_en : 1'b1;
        sx_run  = ~osc_q.sx_dis;
        p2_run  = pll_q.p2_en;
        osc_tmr = osc_q.tmr_en;
        pll_tmr = pll_q.tmr_en;
    end

endmodule

// File: rtl/pll_rate_calc.sv
// Module: pll_rate_calc
// Computes ref_rate * (mul_code + offset) >> shift_code as a number.
// Assumes RATE_W is wide enough for the largest product; a caller with
// no post shift ties shift_code to zero.
module pll_rate_calc
    import osc_pll_pkg::*;
#(
    parameter int REF_W   = 32,
    parameter int MUL_W   = 6,
    parameter int SHIFT_W = 3,
    parameter int RATE_W  = REF_W + MUL_W + 2
) (
    input  logic [REF_W-1:0]   ref_rate,
    input  logic [MUL_W-1:0]   mul_code,
    input  logic [SHIFT_W-1:0] shift_code,
    output logic [RATE_W-1:0]  rate
);

    localparam int FACT_W = MUL_W + 1;

    logic [FACT_W-1:0] factor;
    logic [RATE_W-1:0] product;

    // Offset multiplier, full-width product, then power-of-two shift.
    always_comb begin
        factor  = FACT_W'(mul_code) + FACT_W'(MUL_OFS);
        product = RATE_W'(ref_rate) * RATE_W'(factor);
        rate    = product >> shift_code;
    end

endmodule

// File: rtl/osc_pll_regs.sv
// Module: osc_pll_regs (top)
// Oscillator and PLL control register block: register storage, effective
// enables and two PLL rate calculators. Assumes a single-cycle register
// port and lock inputs already synchronous to clk.
module osc_pll_regs
    import osc_pll_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int NUM_TMR = 8,
    parameter int REF_W   = 32,
    parameter int MUL_W   = 6,
    parameter int SHIFT_W = 3,
    parameter int RATE_W  = REF_W + MUL_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic               mxtal_force_on,
    input  logic               mxtal_lock,
    input  logic               pll1_lock,
    input  logic [REF_W-1:0]   ref_rate,
    output logic [NUM_TMR-1:0] tmr_slow_sel,
    output logic               mxtal_run,
    output logic               sxtal_run,
    output logic               pll1_run,
    output logic               pll2_run,
    output logic               osc_tmr_en,
    output logic               pll_tmr_en,
    output logic [RATE_W-1:0]  pll1_rate,
    output logic [RATE_W-1:0]  pll2_rate
);

    localparam int MUL_MAX = (1 << MUL_W) - 1 + MUL_OFS;

    osc_ctl_t           osc_q;
    pll_ctl_t           pll_q;
    logic [MUL_W-1:0]   m1_q, m2_q;
    logic [SHIFT_W-1:0] d1_q;

    osc_pll_csr #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_TMR(NUM_TMR),
        .MUL_W(MUL_W), .SHIFT_W(SHIFT_W)
    ) i_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .force_mx_on(mxtal_force_on),
        .mx_lock_i(mxtal_lock), .p1_lock_i(pll1_lock),
        .osc_q(osc_q), .pll_q(pll_q), .tmr_q(tmr_slow_sel),
        .m1_q(m1_q), .d1_q(d1_q), .m2_q(m2_q)
    );

    osc_pll_enables i_en (
        .osc_q(osc_q), .pll_q(pll_q),
        .mx_run(mxtal_run), .sx_run(sxtal_run),
        .p1_run(pll1_run), .p2_run(pll2_run),
        .osc_tmr(osc_tmr_en), .pll_tmr(pll_tmr_en)
    );

    pll_rate_calc #(
        .REF_W(REF_W), .MUL_W(MUL_W), .SHIFT_W(SHIFT_W), .RATE_W(RATE_W)
    ) i_rate1 (
        .ref_rate(ref_rate), .mul_code(m1_q), .shift_code(d1_q), .rate(pll1_rate)
    );

    pll_rate_calc #(
        .REF_W(REF_W), .MUL_W(MUL_W), .SHIFT_W(SHIFT_W), .RATE_W(RATE_W)
    ) i_rate2 (
        .ref_rate(ref_rate), .mul_code(m2_q), .shift_code('0), .rate(pll2_rate)
    );

    // R3
    mx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mxtal_run |-> (osc_q.mx_ovr && !osc_q.mx_en));

    // R4
    p1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll1_run |-> (pll_q.p1_ovr && !pll_q.p1_en));

    // R7
    p1_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (d1_q == '0) |-> (pll1_rate >= (RATE_W'(ref_rate) << 1)));

    // R8
    p2_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll2_rate >= (RATE_W'(ref_rate) << 1))
        && (pll2_rate <= RATE_W'(ref_rate) * RATE_W'(MUL_MAX)));

endmodule

// File: tb/test_osc_pll_regs.sv
`timescale 1ns/1ps
module test_osc_pll_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mxtal_force_on = 1'b0;
    logic        mxtal_lock = 1'b0;
    logic        pll1_lock = 1'b0;
    logic [31:0] ref_rate = 32'd100;
    logic [7:0]  tmr_slow_sel;
    logic        mxtal_run, sxtal_run, pll1_run, pll2_run, osc_tmr_en, pll_tmr_en;
    logic [39:0] pll1_rate, pll2_rate;

    int tests = 0;
    int failed = 0;

    always #2.5 clk = ~clk;

    osc_pll_regs i_osc_pll_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mxtal_force_on(mxtal_force_on), .mxtal_lock(mxtal_lock),
        .pll1_lock(pll1_lock), .ref_rate(ref_rate),
        .tmr_slow_sel(tmr_slow_sel), .mxtal_run(mxtal_run),
        .sxtal_run(sxtal_run), .pll1_run(pll1_run), .pll2_run(pll2_run),
        .osc_tmr_en(osc_tmr_en), .pll_tmr_en(pll_tmr_en),
        .pll1_rate(pll1_rate), .pll2_rate(pll2_rate)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write one word; returns on the falling edge after the capturing edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    initial begin
        #1000000;
        failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] all_sel;
        longint unsigned refs [4];
        refs[0] = 1; refs[1] = 12345; refs[2] = 32'hFFFF_FFFF; refs[3] = 2400000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, r); chk("R1 ctrl", r, 0);
        rd(8'h0C, r); chk("R1 osc", r, 32'h2);
        rd(8'h10, r); chk("R1 pll", r, 0);
        rd(8'h14, r); chk("R1 freq", r, 0);
        chk("R1 runs", {mxtal_run, sxtal_run, pll1_run, pll2_run}, 4'b1110);
        chk("R1 sel", tmr_slow_sel, 0);
        chk("R1 rate", pll1_rate, 200);

        // R2 timer selects at odd positions 15..29
        all_sel = 0;
        for (int k = 0; k < 8; k++) all_sel |= 32'h1 << (15 + 2*k);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, r); chk("R2 readback", r, all_sel);
        chk("R2 sel all", tmr_slow_sel, 8'hFF);
        for (int k = 0; k < 8; k++) begin
            wr(8'h00, 32'h1 << (15 + 2*k));
            chk("R2 single", tmr_slow_sel, 8'h1 << k);
        end
        wr(8'h00, 32'h5555_5555); chk("R2 even bits", tmr_slow_sel, 8'h00);
        wr(8'h00, 32'hAAAA_AAAA); chk("R2 odd bits", tmr_slow_sel, 8'hFF);

        // R3 / R4 all override/enable combinations
        for (int c = 0; c < 4; c++) begin
            logic ov, en;
            ov = c[0]; en = c[1];
            wr(8'h0C, {30'd0, en, ov});
            chk("R3 mxtal_run", mxtal_run, ov ? en : 1'b1);
            rd(8'h0C, r); chk("R3 readback", r, {30'd0, en, ov});
            wr(8'h10, {30'd0, en, ov});
            chk("R4 pll1_run", pll1_run, ov ? en : 1'b1);
            rd(8'h10, r); chk("R4 readback", r, {30'd0, en, ov});
        end

        // R5 direct enables, R10 timer enables
        wr(8'h10, 32'h1000_0000); chk("R5 pll2 on", pll2_run, 1'b1);
        wr(8'h10, 32'h0000_0000); chk("R5 pll2 off", pll2_run, 1'b0);
        wr(8'h0C, 32'h0008_0002); chk("R5 sxtal off", sxtal_run, 1'b0);
        wr(8'h0C, 32'h0000_0002); chk("R5 sxtal on", sxtal_run, 1'b1);
        wr(8'h0C, 32'h0010_0002); chk("R10 osc tmr", osc_tmr_en, 1'b1);
        rd(8'h0C, r); chk("R10 osc readback", r, 32'h0010_0002);
        wr(8'h10, 32'h2000_0000); chk("R10 pll tmr", pll_tmr_en, 1'b1);
        rd(8'h10, r); chk("R10 pll readback", r, 32'h2000_0000);
        wr(8'h0C, 32'h0000_0002); wr(8'h10, 32'h0);

        // R6 status bits sampled from lock inputs, not writable
        @(negedge clk); mxtal_lock = 1'b1; pll1_lock = 1'b1;
        @(negedge clk);
        rd(8'h0C, r); chk("R6 mx stat", r[2], 1'b1);
        rd(8'h10, r); chk("R6 p1 stat", r[2], 1'b1);
        wr(8'h0C, 32'h0000_0002);
        rd(8'h0C, r); chk("R6 mx write0 ignored", r[2], 1'b1);
        @(negedge clk); mxtal_lock = 1'b0; pll1_lock = 1'b0;
        wr(8'h10, 32'h0000_0004);
        rd(8'h10, r); chk("R6 p1 write1 ignored", r, 32'h0);
        rd(8'h0C, r); chk("R6 mx low", r, 32'h2);

        // R7 field mask
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, r); chk("R7 freq mask", r, 32'h3F00_3F07);

        // R7 / R8 rate sweep over all fields
        for (int ri = 0; ri < 4; ri++) begin
            ref_rate = refs[ri][31:0];
            for (int m = 0; m < 64; m++) begin
                for (int d = 0; d < 8; d++) begin
                    longint unsigned e1, e2;
                    wr(8'h14, (32'(63 - m) << 24) | (32'(m) << 8) | 32'(d));
                    e1 = (refs[ri] * longint'(m + 2)) >> d;
                    e2 = refs[ri] * longint'(65 - m);
                    chk("R7 pll1_rate", pll1_rate, e1);
                    chk("R8 pll2_rate", pll2_rate, e2);
                end
            end
        end

        // R9 force alone keeps other bits
        wr(8'h0C, 32'h0008_0001);
        chk("R9 pre", mxtal_run, 1'b0);
        @(negedge clk); mxtal_force_on = 1'b1;
        @(negedge clk); mxtal_force_on = 1'b0;
        rd(8'h0C, r); chk("R9 force", r, 32'h0008_0002);
        chk("R9 run", mxtal_run, 1'b1);
        // R9 force collides with a write of override=1, enable=0
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h0000_0001; mxtal_force_on = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; mxtal_force_on = 1'b0;
        rd(8'h0C, r); chk("R9 collide", r, 32'h0000_0002);

        // R11 unmapped offsets
        wr(8'h00, 32'h0);
        wr(8'h14, 32'h0000_0100);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h0D, 32'hFFFF_FFFF);
        rd(8'h08, r); chk("R11 read 08", r, 0);
        rd(8'h18, r); chk("R11 read 18", r, 0);
        rd(8'h00, r); chk("R11 ctrl kept", r, 0);
        rd(8'h0C, r); chk("R11 osc kept", r, 32'h2);
        rd(8'h10, r); chk("R11 pll kept", r, 0);
        rd(8'h14, r); chk("R11 freq kept", r, 32'h0000_0100);

        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

endmodule